// File: doc/BRIEF.md
# Receive Interrupt Coalescing Unit

This block turns a stream of per-frame receive events into fewer interrupts. Each received frame shows up as a one-cycle pulse with an interrupt-request flag. A frame counts only when that flag is set and the frame-interrupt mask input is high. With coalescing turned off, every counted frame raises the interrupt straight away. With coalescing turned on, two thresholds race each other. One is a frame count. The other is a timeout that starts on the first counted frame after the last interrupt. The interrupt is raised by whichever threshold is reached first.

The timeout runs in units of 64 periods of a selectable time base. Both candidate time bases arrive as enable strobes in the block's single clock domain: one stands for the receive interface clock and the other for the system clock. The interrupt output is a sticky pending bit, and the host clears it with a one-cycle acknowledge.

Top module: `rx_irq_coalesce`

## Requirements
- R1: With coal_en low, a counted frame (pulse, flag and mask all high) sets irq on the next clock edge.
- R2: A frame whose flag is low, or that arrives while frame_irq_mask is low, is ignored. It raises no interrupt, adds nothing to the frame count and does not start the timeout.
- R3: With coal_en high, irq rises on the clock edge that follows the counted frame that brings the count since the last interrupt up to cnt_thresh.
- R4: tb_sel = 0 makes the timeout advance on rx_stb, and tb_sel = 1 makes it advance on sys_stb. Strobes from the source that is not selected have no effect.
- R5: The timeout is loaded on the first counted frame after an interrupt. If the count threshold has not been met, irq rises on the edge after the 64*tmr_thresh-th selected strobe that follows that frame.
- R6: After an interrupt fires, the frame count returns to zero and the timeout stops. The timeout starts again only on the next counted frame.
- R7: irq is 0 after reset and stays set until irq_ack is high for a cycle. If a new interrupt condition occurs in the same cycle as irq_ack, irq stays set.
- R8: When the count threshold and the timeout are reached in the same cycle, only one interrupt results and both mechanisms restart.
- R9: A threshold input of zero behaves as a value of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_pulse | input | 1 | One-cycle pulse per received frame |
| frame_irq_req | input | 1 | Interrupt-request flag of the frame |
| frame_irq_mask | input | 1 | Frame interrupt enable |
| coal_en | input | 1 | Coalescing enable |
| tb_sel | input | 1 | Time base select: 0 = rx_stb, 1 = sys_stb |
| rx_stb | input | 1 | Receive-clock strobe |
| sys_stb | input | 1 | System-clock strobe |
| cnt_thresh | input | CNT_W (8) | Frame count threshold |
| tmr_thresh | input | TMR_W (16) | Timeout in units of 64 strobes |
| irq_ack | input | 1 | Clears the pending interrupt |
| irq | output | 1 | Pending interrupt, registered |

## Verification
The bench builds the block with its default values: an 8-bit count threshold, a 16-bit timeout and a divide-by-64 time base. Because the timeout thresholds used are small (0 to 3 units), each timeout expires within a few hundred strobes. This lets the bench check the exact expiry cycle, the selection of the time base and the case where the count and the timeout finish on the same strobe. Zero thresholds are also driven, which tests their saturation to 1 at full register width.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
  typedef enum logic {
    TB_RX  = 1'b0,
    TB_SYS = 1'b1
  } tb_sel_e;

  localparam int unsigned DEF_DIV = 64;
endpackage

// File: rtl/rxc_prescaler.sv
module rxc_prescaler #(
  parameter int unsigned DIV = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  input  logic stb,
  output logic tick
);
  localparam int unsigned PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pcnt;

  assign tick = run & stb & (pcnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pcnt <= '0;
    end else if (run && stb) begin
      pcnt <= tick ? '0 : pcnt + PW'(1);
    end
  end
endmodule

// File: rtl/rxc_frame_counter.sv
module rxc_frame_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             qual,
  input  logic [CNT_W-1:0] thresh,
  output logic             hit
);
  logic [CNT_W-1:0] seen;
  logic [CNT_W-1:0] thr_eff;
  logic [CNT_W:0]   next_seen;

  assign thr_eff   = (thresh == '0) ? CNT_W'(1) : thresh;
  assign next_seen = {1'b0, seen} + (CNT_W+1)'(1);
  assign hit       = qual & (next_seen >= {1'b0, thr_eff});

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      seen <= '0;
    end else if (qual && (seen != '1)) begin
      seen <= seen + CNT_W'(1);
    end
  end
endmodule

// File: rtl/rxc_timer.sv
module rxc_timer #(
  parameter int unsigned TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             qual,
  input  logic             tick,
  input  logic [TMR_W-1:0] thresh,
  output logic             armed,
  output logic             hit
);
  logic [TMR_W-1:0] remain;
  logic [TMR_W-1:0] thr_eff;

  assign thr_eff = (thresh == '0) ? TMR_W'(1) : thresh;
  assign hit     = armed & tick & (remain == TMR_W'(1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      armed  <= 1'b0;
      remain <= '0;
    end else if (!armed) begin
      if (qual) begin
        armed  <= 1'b1;
        remain <= thr_eff;
      end
    end else if (tick) begin
      remain <= remain - TMR_W'(1);
    end
  end
endmodule

// File: rtl/rx_irq_coalesce.sv
module rx_irq_coalesce
  import rxc_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned TMR_W = 16,
  parameter int unsigned DIV   = DEF_DIV
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_pulse,
  input  logic             frame_irq_req,
  input  logic             frame_irq_mask,
  input  logic             coal_en,
  input  logic             tb_sel,
  input  logic             rx_stb,
  input  logic             sys_stb,
  input  logic [CNT_W-1:0] cnt_thresh,
  input  logic [TMR_W-1:0] tmr_thresh,
  input  logic             irq_ack,
  output logic             irq
);
  logic qual;
  logic stb;
  logic tick;
  logic cnt_hit;
  logic tmr_hit;
  logic armed;
  logic fire;
  logic restart;

  assign qual    = frame_pulse & frame_irq_req & frame_irq_mask;
  assign stb     = (tb_sel == TB_SYS) ? sys_stb : rx_stb;
  assign fire    = coal_en ? (cnt_hit | tmr_hit) : qual;
  assign restart = fire | ~coal_en;

  rxc_frame_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .clr    (restart),
    .qual   (qual),
    .thresh (cnt_thresh),
    .hit    (cnt_hit)
  );

  rxc_prescaler #(.DIV(DIV)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .clr  (restart),
    .run  (armed),
    .stb  (stb),
    .tick (tick)
  );

  rxc_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk    (clk),
    .rst    (rst),
    .clr    (restart),
    .qual   (qual),
    .tick   (tick),
    .thresh (tmr_thresh),
    .armed  (armed),
    .hit    (tmr_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
    end else if (fire) begin
      irq <= 1'b1;
    end else if (irq_ack) begin
      irq <= 1'b0;
    end
  end
endmodule

// File: rtl/rxc_checker.sv
module rxc_checker (
  input logic clk,
  input logic rst,
  input logic coal_en,
  input logic qual,
  input logic fire,
  input logic armed,
  input logic irq_ack,
  input logic irq
);
  AST_DISABLED_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
    (!coal_en && qual) |=> irq); // R1

  AST_IGNORED_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
    (!coal_en && !qual && !irq) |=> !irq); // R2

  AST_ARM_ON_FRAME: assert property (@(posedge clk) disable iff (rst)
    $rose(armed) |-> $past(qual)); // R6

  AST_FIRE_STOPS_TIMER: assert property (@(posedge clk) disable iff (rst)
    fire |=> !armed); // R6

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && !fire) |=> !irq); // R7

  AST_FIRE_WINS: assert property (@(posedge clk) disable iff (rst)
    fire |=> irq); // R7
endmodule

bind rx_irq_coalesce rxc_checker u_chk (
  .clk     (clk),
  .rst     (rst),
  .coal_en (coal_en),
  .qual    (qual),
  .fire    (fire),
  .armed   (armed),
  .irq_ack (irq_ack),
  .irq     (irq)
);

// File: tb/sim_rx_irq_coalesce.sv
module sim_rx_irq_coalesce;
  localparam int DIV = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_pulse = 1'b0, frame_irq_req = 1'b0, frame_irq_mask = 1'b1;
  logic        coal_en = 1'b0, tb_sel = 1'b0, rx_stb = 1'b0, sys_stb = 1'b0;
  logic [7:0]  cnt_thresh = 8'd1;
  logic [15:0] tmr_thresh = 16'd1;
  logic        irq_ack = 1'b0;
  logic        irq;

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R7";

  int m_cnt = 0, m_left = 0;
  bit m_armed = 0, m_irq = 0;

  always #2 clk = ~clk;

  rx_irq_coalesce u0 (
    .clk(clk), .rst(rst), .frame_pulse(frame_pulse), .frame_irq_req(frame_irq_req),
    .frame_irq_mask(frame_irq_mask), .coal_en(coal_en), .tb_sel(tb_sel),
    .rx_stb(rx_stb), .sys_stb(sys_stb), .cnt_thresh(cnt_thresh),
    .tmr_thresh(tmr_thresh), .irq_ack(irq_ack), .irq(irq)
  );

  // Behavioural reference: counts frames and remaining strobes as plain integers
  always @(posedge clk) begin
    bit q, s, th, ch, f;
    int ct, tt;
    if (rst) begin
      m_cnt = 0; m_left = 0; m_armed = 0; m_irq = 0;
    end else begin
      q  = frame_pulse && frame_irq_req && frame_irq_mask;
      f  = 0;
      if (!coal_en) begin
        f = q; m_cnt = 0; m_armed = 0;
      end else begin
        ct = (cnt_thresh == 0) ? 1 : int'(cnt_thresh);
        tt = (tmr_thresh == 0) ? 1 : int'(tmr_thresh);
        s  = tb_sel ? sys_stb : rx_stb;
        th = m_armed && s && (m_left == 1);
        ch = q && (m_cnt + 1 >= ct);
        f  = th || ch;
        if (f) begin
          m_cnt = 0; m_armed = 0;
        end else begin
          if (m_armed && s) m_left--;
          if (q) m_cnt++;
          if (q && !m_armed) begin m_armed = 1; m_left = tt * DIV; end
        end
      end
      if (f) m_irq = 1;
      else if (irq_ack) m_irq = 0;
    end
  end

  task automatic check(input bit act, input bit exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: irq=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // advance one edge, then compare against the model away from the edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    check(irq, m_irq, cur_req);
    frame_pulse = 0; irq_ack = 0; rx_stb = 0; sys_stb = 0;
  endtask

  task automatic frame(input bit flag);
    frame_pulse = 1; frame_irq_req = flag; step();
  endtask

  task automatic strobes(input int n, input bit sys);
    for (int i = 0; i < n; i++) begin
      if (sys) sys_stb = 1; else rx_stb = 1;
      step();
    end
  endtask

  task automatic ack();
    irq_ack = 1; step();
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(irq, 1'b0, "R7 reset");

    // R1: disabled coalescing passes each frame
    cur_req = "R1";
    frame(1); check(irq, 1'b1, "R1");
    ack();    check(irq, 1'b0, "R7 ack");
    frame(1); check(irq, 1'b1, "R1 again");
    ack();

    // R2: masked frames and unflagged frames
    cur_req = "R2";
    frame_irq_mask = 0;
    frame(1); frame(1); check(irq, 1'b0, "R2 masked");
    frame_irq_mask = 1;
    coal_en = 1; cnt_thresh = 3; tmr_thresh = 16'd1000;
    frame(0); frame(0); frame(1); frame(1);
    check(irq, 1'b0, "R2 unflagged not counted");
    frame(1); check(irq, 1'b1, "R2/R3 third flagged");
    ack();

    // R3: count threshold of 4
    cur_req = "R3";
    cnt_thresh = 4;
    for (int i = 0; i < 3; i++) begin frame(1); step(); end
    check(irq, 1'b0, "R3 before threshold");
    frame(1); check(irq, 1'b1, "R3 at threshold");
    ack();

    // R4/R5: time base select, rx strobes
    cur_req = "R5";
    cnt_thresh = 200; tmr_thresh = 2; tb_sel = 0;
    frame(1);
    strobes(300, 1); check(irq, 1'b0, "R4 unselected sys strobes");
    strobes(127, 0); check(irq, 1'b0, "R5 one strobe early");
    strobes(1, 0);   check(irq, 1'b1, "R5 expiry rx");
    ack();

    // R6: no re-arm without a frame
    cur_req = "R6";
    strobes(200, 0); check(irq, 1'b0, "R6 timer idle");

    // R4: system strobes selected
    cur_req = "R4";
    tb_sel = 1; tmr_thresh = 1;
    frame(1);
    strobes(100, 0); check(irq, 1'b0, "R4 unselected rx strobes");
    strobes(63, 1);  check(irq, 1'b0, "R4 sys early");
    strobes(1, 1);   check(irq, 1'b1, "R4 expiry sys");

    // R7: new condition in the ack cycle wins
    cur_req = "R7";
    coal_en = 0;
    irq_ack = 1; frame(1); check(irq, 1'b1, "R7 fire beats ack");
    ack(); check(irq, 1'b0, "R7 cleared");

    // R8: count and timeout on the same cycle
    cur_req = "R8";
    coal_en = 1; tb_sel = 0; cnt_thresh = 2; tmr_thresh = 1;
    frame(1);
    strobes(63, 0);
    rx_stb = 1; frame(1); check(irq, 1'b1, "R8 joint fire");
    ack();
    strobes(200, 0); check(irq, 1'b0, "R8 both restarted");
    frame(1); check(irq, 1'b0, "R8 count restarted");
    frame(1); check(irq, 1'b1, "R8 count reaches 2");
    ack();

    // R9: zero thresholds saturate to 1
    cur_req = "R9";
    cnt_thresh = 0;
    frame(1); check(irq, 1'b1, "R9 zero count");
    ack();
    cnt_thresh = 5; tmr_thresh = 0;
    frame(1);
    strobes(63, 0); check(irq, 1'b0, "R9 zero timer early");
    strobes(1, 0);  check(irq, 1'b1, "R9 zero timer expiry");
    ack();
    step();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule